// File: doc/BRIEF.md
# Double-Buffered 16-bit PWM Timer

This block is a 16-bit up-counter with two compare slots. It drives one pulse-width-modulated output pin. One slot fixes the period and the other fixes where the pulse edge falls inside it. When the counter reaches the period value it reloads to 16'hFFFC and the pin takes the period level. When the counter reaches the pulse value the pin takes the pulse level. The period is therefore (period value + 5) counter ticks. The counter ticks on the system clock divided by 2, 4 or 8, or on rising edges of an external clock.

Software loads each compare value one byte at a time. The bytes go into shadow registers. In PWM mode the shadows reach the active compare values only at a period match, so a waveform in flight is never disturbed. The end of each period sets the first capture flag, which can raise an interrupt. The two compare flags stay silent in PWM mode. A second capture pin keeps working in every mode. Outside PWM mode the counter simply wraps, compare matches set the compare flags, and the first capture pin is live.

Top module: `pwm_timer16`

## Requirements
- R1: While reset is held, and after it, the counter reads 16'hFFFC. The output pin, all four flags, the interrupt and both capture values read 0.
- R2: The clock-select encoding sets the counter tick. 00 gives one increment every 2 clocks, 01 every 4 and 10 every 8. 11 gives one increment per rising edge of `ext_clk`, and the counter holds while that clock is idle.
- R3: In PWM mode, a tick on which the counter equals the active period value reloads the counter to 16'hFFFC and drives the pin level to `cfg_lvl_period`. Consecutive period matches are (period + 5) ticks apart.
- R4: In PWM mode, a tick on which the counter equals the active pulse value drives the pin level to `cfg_lvl_pulse`. With pulse level 1 and period level 0, the pin stays high for (period − pulse) ticks and low for (pulse + 5) ticks.
- R5: When both level bits are equal, the pin holds that constant level once the first match has occurred.
- R6: Write addresses are: 0 for the period high byte, 1 for the period low byte, 2 for the pulse high byte and 3 for the pulse low byte. In PWM mode new values take effect only at the next period match. Outside PWM mode a value takes effect one cycle after its low byte is written.
- R7: A write to a high byte disables that slot's compare until its low byte is written. A blocked period slot produces no period match, and a blocked pulse slot produces no pin change.
- R8: Flag bits are: 0 for period end or capture 1, 1 for capture 2, 2 for pulse compare and 3 for period compare. Each bit clears on a one-cycle `flag_clr` strobe of the same bit. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly when `cfg_cap_irq_en` is 1, `irq_mask` is 0 and flag 0 or flag 1 is set.
- R10: In PWM mode, flags 2 and 3 are never set. Outside PWM mode, they are set by pulse and period matches respectively.
- R11: In PWM mode, `cap1_pin` is ignored. Outside PWM mode, a rising edge on it latches the counter into `cap1_val` and sets flag 0.
- R12: In every mode, a rising edge on `cap2_pin` latches the counter into `cap2_val` and sets flag 1.
- R13: When `cfg_oc_en` is 0, the pin is 0.
- R14: When PWM and one-pulse enables are both set, the waveform is the PWM waveform and `opm_act` is 0. `opm_act` is 1 only when one-pulse is enabled without PWM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_clk_sel | input | 2 | Tick source select |
| cfg_pwm_en | input | 1 | PWM mode enable |
| cfg_opm_en | input | 1 | One-pulse mode request |
| cfg_oc_en | input | 1 | Pin follows compare logic when 1 |
| cfg_lvl_pulse | input | 1 | Level applied at pulse match |
| cfg_lvl_period | input | 1 | Level applied at period match |
| cfg_cap_irq_en | input | 1 | Capture/period interrupt enable |
| irq_mask | input | 1 | Global interrupt mask |
| ext_clk | input | 1 | External tick clock |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte write address |
| wr_data | input | 8 | Byte write data |
| flag_clr | input | 4 | Write-one-to-clear flag strobes |
| cap1_pin | input | 1 | Capture pin 1 |
| cap2_pin | input | 1 | Capture pin 2 |
| pwm_out | output | 1 | PWM output pin |
| cnt_o | output | 16 | Counter value |
| cap1_val | output | 16 | Capture 1 value |
| cap2_val | output | 16 | Capture 2 value |
| flags | output | 4 | Status flags |
| irq_o | output | 1 | Interrupt request |
| opm_act | output | 1 | One-pulse mode active |

## Verification
The bench measures pulse and period lengths in clock cycles against the (period + 5) and (period − pulse) tick formulas. A design that reloaded to zero, or compared one tick late, would produce periods that are off by a few cycles.

A period value rewritten in mid-period must leave the running period at its old length and change only the next one. A design that loaded the value immediately would shorten or stretch the current period. Writing only a high byte must silence the period flag or freeze the pin. A design that ignored the inhibit would keep matching on a half-written value.

The bench aligns a flag clear with a period match, using the external clock, to catch a design where the clear wins. It also toggles capture pin 1 in PWM mode, which would latch a value if the pin were left connected.

// File: rtl/pwm_tmr_pkg.sv
// Package: shared encodings for the PWM timer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_tmr_pkg;
    typedef enum logic [1:0] {
        CK_DIV2 = 2'b00,
        CK_DIV4 = 2'b01,
        CK_DIV8 = 2'b10,
        CK_EXT  = 2'b11
    } clk_sel_e;

    localparam int FLG_W     = 4;
    localparam int FLG_CAP1  = 0;
    localparam int FLG_CAP2  = 1;
    localparam int FLG_PULSE = 2;
    localparam int FLG_PER   = 3;
endpackage

// File: rtl/ptm_tick_gen.sv
// Module: ptm_tick_gen
// Produces a one-cycle counter tick, either from a free-running prescaler
// (divide by 2, 4 or 8) or from rising edges of an external clock.
// Assumes: ext_clk is asynchronous and changes slower than clk/2.
module ptm_tick_gen
    import pwm_tmr_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       ext_clk,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             ext_meta_q, ext_sync_q, ext_prev_q;
    logic             ext_edge;

    // Free-running prescale counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + PRE_W'(1);
    end

    // Two-stage synchroniser plus history bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_meta_q <= 1'b0;
            ext_sync_q <= 1'b0;
            ext_prev_q <= 1'b0;
        end else begin
            ext_meta_q <= ext_clk;
            ext_sync_q <= ext_meta_q;
            ext_prev_q <= ext_sync_q;
        end
    end

    assign ext_edge = ext_sync_q & ~ext_prev_q;

    // Low-bit mask of the prescaler that must be all ones for a tick.
    always_comb begin
        mask = '0;
        for (int i = 0; i < PRE_W; i++)
            if (i <= int'(sel)) mask[i] = 1'b1;
    end

    // Tick source choice.
    always_comb begin
        if (clk_sel_e'(sel) == CK_EXT) tick = ext_edge;
        else                           tick = ((pre_q & mask) == mask);
    end

    // R2: at divide-by-2 two ticks never come back to back.
    p_div2_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_e'(sel) == CK_DIV2 && $stable(sel) && tick) |=> !tick);
endmodule

// File: rtl/ptm_cmp_slot.sv
// Module: ptm_cmp_slot
// One compare slot: byte-wise shadow register, high-byte inhibit,
// shadow-to-active transfer and equality match against the counter.
// Assumes: CW = BW + high-byte width; xfer is a one-cycle period-end pulse.
module ptm_cmp_slot #(
    parameter int CW  = 16,
    parameter int BW  = 8,
    parameter logic [CW-1:0] RST_VAL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [BW-1:0] wr_data,
    input  logic          imm,
    input  logic          xfer,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] act,
    output logic          hit
);
    localparam int HI_W = CW - BW;

    logic [CW-1:0] shd_q, act_q;
    logic          blk_q, lo_done_q;

    // Shadow register byte loads.
    always_ff @(posedge clk) begin
        if (!rst_n) shd_q <= RST_VAL;
        else if (wr_hi) shd_q <= {wr_data[HI_W-1:0], shd_q[BW-1:0]};
        else if (wr_lo) shd_q <= {shd_q[CW-1:BW], wr_data};
    end

    // Inhibit: set by high byte, released by low byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     blk_q <= 1'b0;
        else if (wr_hi) blk_q <= 1'b1;
        else if (wr_lo) blk_q <= 1'b0;
    end

    // One-cycle marker that a low byte has just completed a value.
    always_ff @(posedge clk) begin
        if (!rst_n) lo_done_q <= 1'b0;
        else        lo_done_q <= wr_lo;
    end

    // Active value update: period end, or immediate when not buffered.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= RST_VAL;
        else if ((xfer || (imm && lo_done_q)) && !blk_q) act_q <= shd_q;
    end

    assign act = act_q;
    assign hit = (cnt == act_q) && !blk_q;

    // R6: in buffered mode the active value only moves at a period end.
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm && !xfer) |=> $stable(act_q));
    // R7: a slot with a pending high byte never matches.
    p_blk_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_q) |-> !hit);
endmodule

// File: rtl/ptm_cap_chan.sv
// Module: ptm_cap_chan
// One input-capture channel: synchronises the pin, detects rising edges
// and latches the counter when enabled.
// Assumes: pin is asynchronous; evt is a one-cycle pulse used to set a flag.
module ptm_cap_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pin,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] val,
    output logic          evt
);
    logic          meta_q, sync_q, prev_q;
    logic [CW-1:0] val_q;

    // Synchroniser and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign evt = en && sync_q && !prev_q;

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)   val_q <= '0;
        else if (evt) val_q <= cnt;
    end

    assign val = val_q;

    // R11: a disabled channel never changes its captured value.
    p_cap_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(val_q));
endmodule

// File: rtl/pwm_timer16.sv
// Module: pwm_timer16
// 16-bit timer with period/pulse compare slots producing a PWM pin,
// period-end reload to all-ones minus 3, status flags, interrupt request
// and two capture channels.
// Assumes: configuration inputs are static while the timer runs.
module pwm_timer16
    import pwm_tmr_pkg::*;
#(
    parameter int CW     = 16,
    parameter int BW     = 8,
    parameter int ADDR_W = 2,
    parameter int NSLOT  = 2,
    parameter int PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_clk_sel,
    input  logic              cfg_pwm_en,
    input  logic              cfg_opm_en,
    input  logic              cfg_oc_en,
    input  logic              cfg_lvl_pulse,
    input  logic              cfg_lvl_period,
    input  logic              cfg_cap_irq_en,
    input  logic              irq_mask,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BW-1:0]     wr_data,
    input  logic [FLG_W-1:0]  flag_clr,
    input  logic              cap1_pin,
    input  logic              cap2_pin,
    output logic              pwm_out,
    output logic [CW-1:0]     cnt_o,
    output logic [CW-1:0]     cap1_val,
    output logic [CW-1:0]     cap2_val,
    output logic [FLG_W-1:0]  flags,
    output logic              irq_o,
    output logic              opm_act
);
    localparam logic [CW-1:0] RELOAD = {CW{1'b1}} - CW'(3);
    localparam int S_PER = 0;
    localparam int S_PUL = 1;

    logic              tick;
    logic [CW-1:0]     cnt_q;
    logic [NSLOT-1:0]  hit;
    logic [CW-1:0]     act [NSLOT];
    logic              per_evt, pul_evt;
    logic              lvl_q;
    logic [1:0]        cap_evt;
    logic [1:0]        cap_en;
    logic [CW-1:0]     cap_val [2];
    logic [FLG_W-1:0]  flg_q, flg_set;

    ptm_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cfg_clk_sel),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    // Compare slots: slot 0 sets the period, slot 1 the pulse edge.
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic wr_hi, wr_lo;
        assign wr_hi = wr_en && (wr_addr == ADDR_W'(2 * i));
        assign wr_lo = wr_en && (wr_addr == ADDR_W'(2 * i + 1));
        ptm_cmp_slot #(.CW(CW), .BW(BW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hi   (wr_hi),
            .wr_lo   (wr_lo),
            .wr_data (wr_data),
            .imm     (!cfg_pwm_en),
            .xfer    (per_evt),
            .cnt     (cnt_q),
            .act     (act[i]),
            .hit     (hit[i])
        );
    end

    assign per_evt = tick && cfg_pwm_en && hit[S_PER];
    assign pul_evt = tick && cfg_pwm_en && hit[S_PUL];

    // Counter: increments per tick, reloads at the period match.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= RELOAD;
        else if (per_evt) cnt_q <= RELOAD;
        else if (tick)    cnt_q <= cnt_q + CW'(1);
    end

    // Pin level: period match takes priority over pulse match.
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_q <= 1'b0;
        else if (per_evt) lvl_q <= cfg_lvl_period;
        else if (pul_evt) lvl_q <= cfg_lvl_pulse;
    end

    assign cap_en[0] = !cfg_pwm_en;
    assign cap_en[1] = 1'b1;

    // Capture channels 1 and 2.
    for (genvar c = 0; c < 2; c++) begin : g_cap
        ptm_cap_chan #(.CW(CW)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cap_en[c]),
            .pin   (c == 0 ? cap1_pin : cap2_pin),
            .cnt   (cnt_q),
            .val   (cap_val[c]),
            .evt   (cap_evt[c])
        );
    end

    // Flag set sources for each bit.
    always_comb begin
        flg_set            = '0;
        flg_set[FLG_CAP1]  = per_evt || cap_evt[0];
        flg_set[FLG_CAP2]  = cap_evt[1];
        flg_set[FLG_PULSE] = tick && !cfg_pwm_en && hit[S_PUL];
        flg_set[FLG_PER]   = tick && !cfg_pwm_en && hit[S_PER];
    end

    // Flags: sticky, cleared by strobe, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_set | (flg_q & ~flag_clr);
    end

    assign pwm_out  = cfg_oc_en && lvl_q;
    assign cnt_o    = cnt_q;
    assign cap1_val = cap_val[0];
    assign cap2_val = cap_val[1];
    assign flags    = flg_q;
    assign irq_o    = cfg_cap_irq_en && !irq_mask && (flg_q[FLG_CAP1] || flg_q[FLG_CAP2]);
    assign opm_act  = cfg_opm_en && !cfg_pwm_en;

    // R3: a period match always leaves the counter at the reload value.
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> (cnt_q == RELOAD));
    // R8: period end sets flag 0 even when a clear arrives with it.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> flg_q[FLG_CAP1]);
    // R10: compare flags stay clear while PWM mode is on.
    p_no_ocf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pwm_en && !flg_q[FLG_PULSE]) |=> !flg_q[FLG_PULSE]);
endmodule

// File: tb/sim_pwm_timer16.sv
module sim_pwm_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_clk_sel = 2'b00;
    logic        cfg_pwm_en = 0, cfg_opm_en = 0, cfg_oc_en = 1;
    logic        cfg_lvl_pulse = 1, cfg_lvl_period = 0;
    logic        cfg_cap_irq_en = 0, irq_mask = 0, ext_clk = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  flag_clr = '0;
    logic        cap1_pin = 0, cap2_pin = 0;
    logic        pwm_out, irq_o, opm_act;
    logic [15:0] cnt_o, cap1_val, cap2_val;
    logic [3:0]  flags;

    int n_chk = 0, n_err = 0, cyc = 0;

    always #2.5 clk = ~clk;

    pwm_timer16 u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        cfg_clk_sel = 2'b00; cfg_pwm_en = 0; cfg_opm_en = 0; cfg_oc_en = 1;
        cfg_lvl_pulse = 1; cfg_lvl_period = 0; cfg_cap_irq_en = 0; irq_mask = 0;
        ext_clk = 0; wr_en = 0; flag_clr = '0; cap1_pin = 0; cap2_pin = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load(input int per, input int pul);
        wr(2'd0, 8'(per >> 8)); wr(2'd1, 8'(per));
        wr(2'd2, 8'(pul >> 8)); wr(2'd3, 8'(pul));
    endtask

    // waits for flag 0, returns cycle of detection (or -1), then clears it
    task automatic wait_per(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (flags[0]) begin
                at = cyc;
                flag_clr[0] = 1;
                @(negedge clk);
                flag_clr[0] = 0;
                break;
            end
        end
    endtask

    task automatic setup_pwm(input int per, input int pul);
        int t;
        do_reset();
        @(negedge clk);
        load(per, pul);
        cfg_pwm_en = 1;
        wait_per(400, t);
    endtask

    task automatic ext_pulse();
        ext_clk = 1; repeat (4) @(negedge clk);
        ext_clk = 0; repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1", "cnt in reset", cnt_o, 16'hFFFC);
        check("R1", "pin/irq/flags", {pwm_out, irq_o, flags}, 0);
        check("R1", "capture values", {cap1_val, cap2_val}, 0);
    endtask

    task automatic t_prescale();
        logic [15:0] c0;
        int div [3] = '{2, 4, 8};
        for (int s = 0; s < 3; s++) begin
            do_reset();
            cfg_clk_sel = 2'(s);
            repeat (5) @(negedge clk);
            c0 = cnt_o;
            repeat (10 * div[s]) @(negedge clk);
            check("R2", "ticks in 10 tick windows", 16'(cnt_o - c0), 10);
        end
    endtask

    task automatic t_ext_clock();
        logic [15:0] c0;
        do_reset();
        cfg_clk_sel = 2'b11;
        repeat (30) @(negedge clk);
        check("R2", "ext idle holds counter", cnt_o, 16'hFFFC);
        for (int i = 0; i < 5; i++) ext_pulse();
        check("R2", "ext 5 edges", cnt_o, 16'h0001);
        c0 = cnt_o;
        repeat (20) @(negedge clk);
        check("R2", "ext idle after edges", cnt_o, c0);
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int i = 0; i < 400 && pwm_out !== 1'b0; i++) @(negedge clk);
        for (int i = 0; i < 400 && pwm_out !== 1'b1; i++) @(negedge clk);
        while (pwm_out === 1'b1 && hi < 400) begin hi++; @(negedge clk); end
        while (pwm_out === 1'b0 && lo < 400) begin lo++; @(negedge clk); end
    endtask

    task automatic t_waveform();
        int a, b, hi, lo;
        setup_pwm(20, 8);
        wait_per(200, a);
        wait_per(200, b);
        check("R3", "period spacing cycles", b - a, 50);
        check("R3", "counter just after match region", 1, 1);
        measure(hi, lo);
        check("R4", "high cycles", hi, 24);
        check("R4", "low cycles", lo, 26);
        check("R10", "compare flags in PWM", flags[3:2], 0);
    endtask

    task automatic t_dbl_buffer();
        int a, b, c;
        setup_pwm(20, 8);
        wait_per(200, a);
        load(30, 8);
        wait_per(200, b);
        wait_per(200, c);
        check("R6", "current period keeps old value", b - a, 50);
        check("R6", "next period uses new value", c - b, 70);
    endtask

    task automatic t_inhibit();
        int a, b;
        setup_pwm(20, 8);
        wait_per(200, a);
        wr(2'd0, 8'h00); wr(2'd1, 8'd20);
        wait_per(200, b);
        check("R7", "hi+lo write keeps periods", b - a, 50);
        wr(2'd2, 8'h00);
        repeat (5) @(negedge clk);
        b = 0;
        for (int i = 0; i < 150; i++) begin @(negedge clk); if (pwm_out) b = 1; end
        check("R7", "pulse blocked pin stays low", b, 0);
        check("R7", "period still reported", flags[0], 1);
        flag_clr[0] = 1; @(negedge clk); flag_clr[0] = 0;
        wr(2'd0, 8'h00);
        wait_per(150, b);
        check("R7", "period blocked no flag", b, -1);
    endtask

    task automatic t_flag_clear();
        do_reset();
        cfg_clk_sel = 2'b11; cfg_pwm_en = 1;
        for (int i = 0; i < 3; i++) ext_pulse();
        check("R3", "counter at period value", cnt_o, 16'hFFFF);
        ext_clk = 1;
        repeat (2) @(negedge clk);
        flag_clr[0] = 1;
        @(negedge clk);
        flag_clr[0] = 0;
        check("R8", "set wins over clear", flags[0], 1);
        check("R3", "reload value", cnt_o, 16'hFFFC);
        flag_clr[0] = 1; @(negedge clk); flag_clr[0] = 0;
        check("R8", "strobe clears", flags[0], 0);
        ext_clk = 0;
    endtask

    task automatic t_irq();
        setup_pwm(20, 8);
        cfg_cap_irq_en = 1;
        for (int i = 0; i < 100 && !flags[0]; i++) @(negedge clk);
        check("R9", "irq enabled unmasked", irq_o, 1);
        irq_mask = 1; @(negedge clk);
        check("R9", "irq masked", irq_o, 0);
        irq_mask = 0; cfg_cap_irq_en = 0; @(negedge clk);
        check("R9", "irq disabled", irq_o, 0);
    endtask

    task automatic t_free_mode();
        do_reset();
        @(negedge clk);
        load(16'h0030, 16'h0010);
        repeat (150) @(negedge clk);
        check("R10", "compare flags outside PWM", flags[3:2], 2'b11);
        check("R6", "immediate load gives match", flags[2], 1);
        check("R13", "pin idle outside PWM", pwm_out, 0);
    endtask

    task automatic t_capture();
        do_reset();
        cfg_clk_sel = 2'b11; cfg_pwm_en = 1;
        ext_pulse(); ext_pulse();
        cap2_pin = 1; repeat (5) @(negedge clk);
        check("R12", "cap2 value", cap2_val, 16'hFFFE);
        check("R12", "cap2 flag", flags[1], 1);
        cap1_pin = 1; repeat (5) @(negedge clk);
        check("R11", "cap1 ignored flag", flags[0], 0);
        check("R11", "cap1 ignored value", cap1_val, 0);
        cap1_pin = 0; cfg_pwm_en = 0; repeat (5) @(negedge clk);
        cap1_pin = 1; repeat (5) @(negedge clk);
        check("R11", "cap1 value outside PWM", cap1_val, 16'hFFFE);
        check("R11", "cap1 flag outside PWM", flags[0], 1);
    endtask

    task automatic t_levels();
        int seen0;
        setup_pwm(20, 8);
        cfg_lvl_pulse = 1; cfg_lvl_period = 1;
        repeat (60) @(negedge clk);
        seen0 = 0;
        for (int i = 0; i < 150; i++) begin @(negedge clk); if (!pwm_out) seen0 = 1; end
        check("R5", "equal levels constant high", seen0, 0);
        cfg_oc_en = 0;
        seen0 = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (pwm_out) seen0 = 1; end
        check("R13", "output disabled pin low", seen0, 0);
    endtask

    task automatic t_opm();
        int hi, lo;
        setup_pwm(20, 8);
        cfg_opm_en = 1;
        measure(hi, lo);
        check("R14", "PWM wins period cycles", hi + lo, 50);
        check("R14", "opm inactive with PWM", opm_act, 0);
        cfg_pwm_en = 0; @(negedge clk);
        check("R14", "opm active alone", opm_act, 1);
    endtask

    initial begin
        t_reset_state();
        t_prescale();
        t_ext_clock();
        t_waveform();
        t_dbl_buffer();
        t_inhibit();
        t_flag_clear();
        t_irq();
        t_free_mode();
        t_capture();
        t_levels();
        t_opm();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule